// File: doc/BRIEF.md
# Instruction Address Watchpoint Channel

This block is one debug watchpoint channel. It watches the stream of instruction fetches and raises a one-cycle event when a fetch address falls inside a programmed, inclusive address window. Before a fetch can count, it must also pass a set of optional preconditions: the address-space identifier, the ISA mode, the privilege bit, an external event counter that must have expired, and an external chain input driven by another channel. The channel compares the address the fetch supplies. That is the effective address when translation is on and the physical address when it is off, so the translation flag does not change the result. When a compact-mode instruction runs as an internal sequence of native operations, only the compact instruction's own fetch can match. The expanded operations are flagged and never match.

Software sets up the channel through a small write port with three targets: the precondition word, the window start and the window end. An enable bit in the precondition word arms the channel. While the channel is armed, the block refuses any change to its settings. The one write it accepts is a precondition write with the enable bit clear, which turns the channel off. A chain-out flag tells other channels that this one has matched at least once since it was armed.

The controller has three states. `ST_OFF` means disabled. `ST_ARMED` means enabled with no match yet. `ST_LATCHED` means enabled with at least one match seen, and chain-out is high. The transitions are:
- `ST_OFF`→`ST_ARMED` on a precondition write with enable set.
- `ST_ARMED`→`ST_LATCHED` on a qualifying fetch.
- `ST_ARMED`→`ST_OFF` and `ST_LATCHED`→`ST_OFF` on a precondition write with enable clear. This disable write takes priority over a fetch in the same cycle.

Top module: `iawp_channel`

## Requirements
- R1: After reset the channel is in ST_OFF, with `match_evt` and `chain_out` both low.
- R2: A fetch qualifies only if start <= address <= end, using unsigned comparison. Both bounds are inclusive, and addresses at or above 0x80000000 are compared as large values.
- R3: While the enable bit (precondition bit 0) is clear, no fetch produces an event, whatever the other fields hold.
- R4: With ASID enable set (bit 1), a fetch qualifies only if `fetch_asid` equals the programmed ASID value (bits [19:12]).
- R5: With ISA-mode enable set (bit 2), a fetch qualifies only if `fetch_isa` equals the programmed mode bit (bit 3).
- R6: With privilege enable set (bit 4), a fetch qualifies only if `fetch_priv` equals the programmed privilege bit (bit 5).
- R7: With counter enable set (bit 6), a fetch qualifies only if `cnt_expired[sel]` is high, where sel is bits [9:8].
- R8: With chain enable set (bit 7), a fetch qualifies only if `chain_in[sel]` is high, where sel is bits [11:10].
- R9: A fetch with `fetch_expanded` high never qualifies. A compact instruction followed by its expanded operations therefore gives exactly one event.
- R10: The value of `fetch_mmu_en` has no effect on matching.
- R11: `match_evt` is high for exactly the one clock that follows each qualifying fetch with `fetch_valid` high. It is low otherwise.
- R12: `chain_out` rises together with the first event and stays high until a precondition write with enable clear.
- R13: While enabled, writes to start (wr_sel=1) and end (wr_sel=2) are ignored. A precondition write (wr_sel=0) with enable set is also ignored. A precondition write with enable clear disables the channel and leaves the other fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Settings write strobe |
| wr_sel | input | 2 | Write target: 0 precondition, 1 start, 2 end, 3 none |
| wr_data | input | ADDR_W | Write data |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_addr | input | ADDR_W | Fetch address as supplied |
| fetch_asid | input | ASID_W | Current address-space identifier |
| fetch_isa | input | 1 | Current ISA mode |
| fetch_priv | input | 1 | Current privilege bit |
| fetch_mmu_en | input | 1 | Translation enabled (informational) |
| fetch_expanded | input | 1 | Fetch is an expanded operation with no own address |
| cnt_expired | input | NCNT | Expired flags of external event counters |
| chain_in | input | NCHAIN | Chain flags from other channels |
| match_evt | output | 1 | One-cycle watchpoint event |
| chain_out | output | 1 | Channel has matched since it was armed |

## Verification
The hardest situation to reach from the ports is a write that arrives while the channel is armed. The bench has to show that the write changed nothing, and the only evidence is later matching behaviour. The bench arms a window, then tries to move the start bound and to switch on an ASID filter. It then fetches an address and ASID combination that matches only under the old settings and expects an event. The unsigned bound case is also hard to observe: it needs a window in the upper half of the address space, so the bench disables the channel, reprograms it, and probes just below and exactly at the top of that window.

// File: rtl/iawp_pkg.sv
package iawp_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_ARMED   = 2'd1,
        ST_LATCHED = 2'd2
    } chan_state_t;

    localparam logic [1:0] SEL_PRE   = 2'd0;
    localparam logic [1:0] SEL_START = 2'd1;
    localparam logic [1:0] SEL_END   = 2'd2;

    localparam int FLD_EN       = 0;
    localparam int FLD_ASID_EN  = 1;
    localparam int FLD_ISA_EN   = 2;
    localparam int FLD_ISA_VAL  = 3;
    localparam int FLD_PRIV_EN  = 4;
    localparam int FLD_PRIV_VAL = 5;
    localparam int FLD_CNT_EN   = 6;
    localparam int FLD_CHN_EN   = 7;
    localparam int FLD_SEL_LO   = 8;

endpackage

// File: rtl/iawp_regs.sv
module iawp_regs
    import iawp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ASID_W = 8,
    parameter int CSEL_W = 2,
    parameter int HSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              chan_on,
    output logic [ADDR_W-1:0] start_q,
    output logic [ADDR_W-1:0] end_q,
    output logic              asid_en_q,
    output logic [ASID_W-1:0] asid_val_q,
    output logic              isa_en_q,
    output logic              isa_val_q,
    output logic              priv_en_q,
    output logic              priv_val_q,
    output logic              cnt_en_q,
    output logic [CSEL_W-1:0] cnt_sel_q,
    output logic              chn_en_q,
    output logic [HSEL_W-1:0] chn_sel_q
);
    localparam int HSEL_LO = FLD_SEL_LO + CSEL_W;
    localparam int ASID_LO = HSEL_LO + HSEL_W;

    logic accept;
    assign accept = wr_en && !chan_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q    <= '0;
            end_q      <= '0;
            asid_en_q  <= 1'b0;
            asid_val_q <= '0;
            isa_en_q   <= 1'b0;
            isa_val_q  <= 1'b0;
            priv_en_q  <= 1'b0;
            priv_val_q <= 1'b0;
            cnt_en_q   <= 1'b0;
            cnt_sel_q  <= '0;
            chn_en_q   <= 1'b0;
            chn_sel_q  <= '0;
        end else if (accept) begin
            if (wr_sel == SEL_START) start_q <= wr_data;
            if (wr_sel == SEL_END)   end_q   <= wr_data;
            if (wr_sel == SEL_PRE) begin
                asid_en_q  <= wr_data[FLD_ASID_EN];
                asid_val_q <= wr_data[ASID_LO +: ASID_W];
                isa_en_q   <= wr_data[FLD_ISA_EN];
                isa_val_q  <= wr_data[FLD_ISA_VAL];
                priv_en_q  <= wr_data[FLD_PRIV_EN];
                priv_val_q <= wr_data[FLD_PRIV_VAL];
                cnt_en_q   <= wr_data[FLD_CNT_EN];
                cnt_sel_q  <= wr_data[FLD_SEL_LO +: CSEL_W];
                chn_en_q   <= wr_data[FLD_CHN_EN];
                chn_sel_q  <= wr_data[HSEL_LO +: HSEL_W];
            end
        end
    end

    // R13
    locked_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && chan_on) |=> ($stable(start_q) && $stable(end_q)
                                && $stable(asid_val_q) && $stable(asid_en_q)));

endmodule

// File: rtl/iawp_qual.sv
module iawp_qual #(
    parameter int ADDR_W = 32,
    parameter int ASID_W = 8,
    parameter int NCNT   = 4,
    parameter int NCHAIN = 4,
    parameter int CSEL_W = 2,
    parameter int HSEL_W = 2
) (
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [ASID_W-1:0] fetch_asid,
    input  logic              fetch_isa,
    input  logic              fetch_priv,
    input  logic              fetch_expanded,
    input  logic [NCNT-1:0]   cnt_expired,
    input  logic [NCHAIN-1:0] chain_in,
    input  logic [ADDR_W-1:0] start_q,
    input  logic [ADDR_W-1:0] end_q,
    input  logic              asid_en_q,
    input  logic [ASID_W-1:0] asid_val_q,
    input  logic              isa_en_q,
    input  logic              isa_val_q,
    input  logic              priv_en_q,
    input  logic              priv_val_q,
    input  logic              cnt_en_q,
    input  logic [CSEL_W-1:0] cnt_sel_q,
    input  logic              chn_en_q,
    input  logic [HSEL_W-1:0] chn_sel_q,
    output logic              hit
);
    logic in_range, asid_ok, isa_ok, priv_ok, cnt_ok, chn_ok;

    always_comb begin
        in_range = (fetch_addr >= start_q) && (fetch_addr <= end_q);
        asid_ok  = !asid_en_q || (fetch_asid == asid_val_q);
        isa_ok   = !isa_en_q  || (fetch_isa  == isa_val_q);
        priv_ok  = !priv_en_q || (fetch_priv == priv_val_q);
        cnt_ok   = !cnt_en_q  || cnt_expired[cnt_sel_q];
        chn_ok   = !chn_en_q  || chain_in[chn_sel_q];
        hit      = fetch_valid && !fetch_expanded && in_range
                   && asid_ok && isa_ok && priv_ok && cnt_ok && chn_ok;
    end

endmodule

// File: rtl/iawp_channel.sv
module iawp_channel
    import iawp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ASID_W = 8,
    parameter int NCNT   = 4,
    parameter int NCHAIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [ASID_W-1:0] fetch_asid,
    input  logic              fetch_isa,
    input  logic              fetch_priv,
    input  logic              fetch_mmu_en,
    input  logic              fetch_expanded,
    input  logic [NCNT-1:0]   cnt_expired,
    input  logic [NCHAIN-1:0] chain_in,
    output logic              match_evt,
    output logic              chain_out
);
    localparam int CSEL_W = (NCNT   > 1) ? $clog2(NCNT)   : 1;
    localparam int HSEL_W = (NCHAIN > 1) ? $clog2(NCHAIN) : 1;

    chan_state_t       state_q, state_d;
    logic              pre_wr, en_wr, dis_wr, hit, chan_on, evt_d;
    logic [ADDR_W-1:0] start_q, end_q;
    logic              asid_en_q, isa_en_q, isa_val_q, priv_en_q, priv_val_q;
    logic              cnt_en_q, chn_en_q;
    logic [ASID_W-1:0] asid_val_q;
    logic [CSEL_W-1:0] cnt_sel_q;
    logic [HSEL_W-1:0] chn_sel_q;
    logic              unused_mmu;

    // The compared address is whichever one the fetch supplies.
    assign unused_mmu = fetch_mmu_en;

    assign pre_wr  = wr_en && (wr_sel == SEL_PRE);
    assign en_wr   = pre_wr && wr_data[FLD_EN];
    assign dis_wr  = pre_wr && !wr_data[FLD_EN];
    assign chan_on = (state_q != ST_OFF);

    iawp_regs #(.ADDR_W(ADDR_W), .ASID_W(ASID_W), .CSEL_W(CSEL_W), .HSEL_W(HSEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .chan_on(chan_on), .start_q(start_q), .end_q(end_q),
        .asid_en_q(asid_en_q), .asid_val_q(asid_val_q),
        .isa_en_q(isa_en_q), .isa_val_q(isa_val_q),
        .priv_en_q(priv_en_q), .priv_val_q(priv_val_q),
        .cnt_en_q(cnt_en_q), .cnt_sel_q(cnt_sel_q),
        .chn_en_q(chn_en_q), .chn_sel_q(chn_sel_q)
    );

    iawp_qual #(.ADDR_W(ADDR_W), .ASID_W(ASID_W), .NCNT(NCNT), .NCHAIN(NCHAIN),
                .CSEL_W(CSEL_W), .HSEL_W(HSEL_W)) u_qual (
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_asid(fetch_asid),
        .fetch_isa(fetch_isa), .fetch_priv(fetch_priv), .fetch_expanded(fetch_expanded),
        .cnt_expired(cnt_expired), .chain_in(chain_in),
        .start_q(start_q), .end_q(end_q),
        .asid_en_q(asid_en_q), .asid_val_q(asid_val_q),
        .isa_en_q(isa_en_q), .isa_val_q(isa_val_q),
        .priv_en_q(priv_en_q), .priv_val_q(priv_val_q),
        .cnt_en_q(cnt_en_q), .cnt_sel_q(cnt_sel_q),
        .chn_en_q(chn_en_q), .chn_sel_q(chn_sel_q),
        .hit(hit)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:     if (en_wr) state_d = ST_ARMED;
            ST_ARMED:   if (dis_wr) state_d = ST_OFF;
                        else if (hit) state_d = ST_LATCHED;
            ST_LATCHED: if (dis_wr) state_d = ST_OFF;
            default:    state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    assign evt_d = hit && chan_on && !dis_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) match_evt <= 1'b0;
        else        match_evt <= evt_d;
    end

    assign chain_out = (state_q == ST_LATCHED);

    // R11
    evt_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |-> $past(fetch_valid && !fetch_expanded && state_q != ST_OFF));

    // R3
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |=> !match_evt);

    // R12
    chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_out && !dis_wr) |=> chain_out);

    // R12
    evt_sets_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |-> chain_out);

    // R2
    hit_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (fetch_addr >= start_q && fetch_addr <= end_q));

    // R9
    expanded_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_expanded |-> !hit);

endmodule

// File: tb/tb_iawp_channel.sv
module tb_iawp_channel;
    localparam int AW = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd3;
    logic [AW-1:0] wr_data = '0;
    logic fetch_valid = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic [7:0] fetch_asid = '0;
    logic fetch_isa = 1'b0, fetch_priv = 1'b0, fetch_mmu_en = 1'b0, fetch_expanded = 1'b0;
    logic [3:0] cnt_expired = '0, chain_in = '0;
    logic match_evt, chain_out;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    iawp_channel dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_asid(fetch_asid),
        .fetch_isa(fetch_isa), .fetch_priv(fetch_priv), .fetch_mmu_en(fetch_mmu_en),
        .fetch_expanded(fetch_expanded), .cnt_expired(cnt_expired), .chain_in(chain_in),
        .match_evt(match_evt), .chain_out(chain_out)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk_pre(input bit en, input bit asid_en, input bit isa_en,
            input bit isa_v, input bit priv_en, input bit priv_v, input bit cnt_en,
            input bit chn_en, input logic [1:0] csel, input logic [1:0] hsel,
            input logic [7:0] asid);
        logic [AW-1:0] w;
        w = '0;
        w[0] = en; w[1] = asid_en; w[2] = isa_en; w[3] = isa_v;
        w[4] = priv_en; w[5] = priv_v; w[6] = cnt_en; w[7] = chn_en;
        w[9:8] = csel; w[11:10] = hsel; w[19:12] = asid;
        return w;
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic arm(input logic [AW-1:0] s, input logic [AW-1:0] e, input logic [AW-1:0] pre);
        wr(2'd0, '0);
        wr(2'd1, s);
        wr(2'd2, e);
        wr(2'd0, pre);
    endtask

    task automatic fetch(input logic [AW-1:0] a, input logic exp_evt, input string tag);
        fetch_valid = 1'b1; fetch_addr = a;
        @(posedge clk); @(negedge clk);
        fetch_valid = 1'b0; fetch_expanded = 1'b0;
        check(tag, match_evt, exp_evt);
    endtask

    task automatic t_reset;
        check("R1 evt", match_evt, 1'b0);
        check("R1 chain", chain_out, 1'b0);
    endtask

    task automatic t_disabled;
        arm(32'h1000, 32'h1FFF, mk_pre(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        fetch(32'h1800, 1'b0, "R3 off no event");
        check("R3 off chain", chain_out, 1'b0);
    endtask

    task automatic t_range;
        arm(32'h1000, 32'h1FFF, mk_pre(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        fetch(32'h0FFF, 1'b0, "R2 below start");
        check("R12 no chain before match", chain_out, 1'b0);
        fetch(32'h1000, 1'b1, "R2 at start");
        check("R12 chain after match", chain_out, 1'b1);
        @(posedge clk); @(negedge clk);
        check("R11 pulse one cycle", match_evt, 1'b0);
        fetch(32'h1FFF, 1'b1, "R2 at end");
        fetch(32'h2000, 1'b0, "R2 past end");
        check("R12 chain holds", chain_out, 1'b1);
        fetch_mmu_en = 1'b1;
        fetch(32'h1500, 1'b1, "R10 mmu on");
        fetch_mmu_en = 1'b0;
        fetch(32'h1500, 1'b1, "R10 mmu off");
        fetch_addr = 32'h1500;
        @(posedge clk); @(negedge clk);
        check("R11 no valid no event", match_evt, 1'b0);
        wr(2'd0, '0);
        check("R12 chain cleared by disable", chain_out, 1'b0);
        arm(32'h8000_0000, 32'hFFFF_FFFF, mk_pre(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        fetch(32'h7FFF_FFFF, 1'b0, "R2 unsigned below");
        fetch(32'hFFFF_FFFF, 1'b1, "R2 unsigned top");
    endtask

    task automatic t_asid;
        arm(32'h100, 32'h1FF, mk_pre(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 8'h5A));
        fetch_asid = 8'h5A; fetch(32'h180, 1'b1, "R4 asid equal");
        fetch_asid = 8'h5B; fetch(32'h180, 1'b0, "R4 asid differ");
        fetch_asid = 8'h00;
    endtask

    task automatic t_isa_priv;
        arm(32'h100, 32'h1FF, mk_pre(1, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0));
        fetch_isa = 1'b1; fetch(32'h100, 1'b1, "R5 isa equal");
        fetch_isa = 1'b0; fetch(32'h100, 1'b0, "R5 isa differ");
        arm(32'h100, 32'h1FF, mk_pre(1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0));
        fetch_priv = 1'b0; fetch(32'h1FF, 1'b1, "R6 priv equal");
        fetch_priv = 1'b1; fetch(32'h1FF, 1'b0, "R6 priv differ");
        fetch_priv = 1'b0;
    endtask

    task automatic t_gates;
        arm(32'h100, 32'h1FF, mk_pre(1, 0, 0, 0, 0, 0, 1, 0, 2'd2, 0, 0));
        cnt_expired = 4'b0100; fetch(32'h150, 1'b1, "R7 selected expired");
        cnt_expired = 4'b1011; fetch(32'h150, 1'b0, "R7 selected not expired");
        cnt_expired = 4'b0000;
        arm(32'h100, 32'h1FF, mk_pre(1, 0, 0, 0, 0, 0, 0, 1, 0, 2'd3, 0));
        chain_in = 4'b1000; fetch(32'h150, 1'b1, "R8 selected chain set");
        chain_in = 4'b0111; fetch(32'h150, 1'b0, "R8 selected chain clear");
        chain_in = 4'b0000;
    endtask

    task automatic t_expanded;
        int evts;
        arm(32'h100, 32'h1FF, mk_pre(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        fetch_expanded = 1'b1; fetch(32'h120, 1'b0, "R9 expanded no event");
        evts = 0;
        fetch_valid = 1'b1; fetch_addr = 32'h130; fetch_expanded = 1'b0;
        @(posedge clk); @(negedge clk);
        if (match_evt) evts++;
        fetch_expanded = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); @(negedge clk);
            if (match_evt) evts++;
        end
        fetch_valid = 1'b0; fetch_expanded = 1'b0;
        @(posedge clk); @(negedge clk);
        if (match_evt) evts++;
        checks++;
        if (evts != 1) begin
            errors++;
            $display("FAIL R9 compact sequence events actual=%0d expected=1", evts);
        end
    endtask

    task automatic t_locked;
        arm(32'h1000, 32'h1FFF, mk_pre(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        wr(2'd1, 32'h3000);
        wr(2'd2, 32'h1000);
        fetch(32'h1800, 1'b1, "R13 bounds write ignored");
        wr(2'd0, mk_pre(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 8'hEE));
        fetch_asid = 8'h11;
        fetch(32'h1800, 1'b1, "R13 precond write ignored");
        fetch_asid = 8'h00;
        wr(2'd0, mk_pre(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 8'hEE));
        check("R13 disable clears chain", chain_out, 1'b0);
        fetch(32'h1800, 1'b0, "R13 disabled no event");
        wr(2'd0, mk_pre(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        fetch(32'h1800, 1'b1, "R13 rearm uses kept bounds");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_disabled;
        t_range;
        t_asid;
        t_isa_priv;
        t_gates;
        t_expanded;
        t_locked;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule